// File: doc/BRIEF.md
# TMDS Link Test Pattern Generator

This block produces one 10-bit TMDS channel word per clock for link bring-up and signal-integrity testing. A one-hot selector picks the output source. The sources are a constant zero, the normal encoded TMDS data passed straight through, a pseudo-random bit sequence, or a user-programmed 80-bit pattern that is replayed as eight 10-bit words. The selected word is registered once before it leaves the block. Serialization and the physical layer sit downstream and are not part of this block.

The pseudo-random engine is a single shared Fibonacci LFSR. It can run one of four polynomials, and each clock it emits 1, 8 or 10 fresh bits according to the width setting. The pattern replayer steps through its eight words in a ring. A repeat field holds each word for between one and eight clocks. Each generator has its own enable and runs whether or not its output is selected. A disabled generator keeps its position.

Top module: `tmds_pattern_gen`

## Requirements
- R1: After a synchronous active-low reset, `tmds_out` is zero. The LFSR holds all ones, the pattern replayer points at word 0 with its hold count cleared, and the last-seen polynomial code is 0.
- R2: `tmds_out` is registered, so it reflects the inputs of the previous clock. Select code 3'b000 gives zero. Every code other than 3'b000, 3'b001, 3'b010 and 3'b100 also gives zero.
- R3: With select 3'b001, `tmds_out` equals `tmds_in` from the previous clock.
- R4: With select 3'b010 the word comes from the LFSR. Polynomial code 2 is x^7+x^6+1, code 0 is x^11+x^9+1, code 1 is x^15+x^14+1 and code 3 is x^31+x^28+1. Each step computes new = s[deg-1]^s[tap-1] and shifts it in at bit 0. The first bit produced in a clock lands in output bit 0, the next in bit 1, and so on.
- R5: Width code 3 emits 10 bits per clock and code 1 emits 8 bits in [7:0]. Code 2 emits 1 bit in [0]. Unused upper bits are 0. Width code 0 is idle: the output is zero and the LFSR does not advance.
- R6: With `prbs_en` low, the LFSR holds its state and its selected output is zero. With `prbs_en` high, the LFSR advances even when another source is selected.
- R7: Any change of the polynomial code reloads the LFSR with all ones. This happens whether or not the generator is enabled. When enabled, the first bits produced after the change come from the all-ones seed.
- R8: With select 3'b100, words are sent starting with pattern bits [9:0], then [19:10], and so on upward, wrapping from [79:70] back to [9:0].
- R9: With `shift_en` high, each pattern word is output for `shift_hold`+1 consecutive clocks, for `shift_hold` from 0 to 7.
- R10: With `shift_en` low, the replayer holds its word position and hold count, and its selected output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmds_in | input | 10 | Normal encoded TMDS word |
| out_sel | input | 3 | One-hot source select (000 zero, 001 data, 010 PRBS, 100 pattern) |
| prbs_en | input | 1 | Pseudo-random generator enable |
| prbs_poly | input | 2 | Polynomial code (0: 11, 1: 15, 2: 7, 3: 31) |
| prbs_width | input | 2 | Bits per clock (0 idle, 1 eight, 2 one, 3 ten) |
| shift_en | input | 1 | Pattern replayer enable |
| shift_hold | input | 3 | Clocks per pattern word minus one |
| shift_pattern | input | 80 | Programmed pattern, word 0 in bits [9:0] |
| tmds_out | output | 10 | Registered test or data word |

## Verification
On every cycle, the assertions check the source-independent output rules: zero and illegal select codes give zero, pass-through follows the input by one cycle, disabled generators output zero, and the narrow PRBS widths leave their upper bits at zero. The actual bit sequences cannot be checked by a single-cycle property. This covers each polynomial's output, the reseed on a polynomial change, the ring order of the pattern words and the per-word hold length. These are shown only by the bench's sweeps, which compare every output word against an arithmetic model over all polynomials, all widths and all eight hold values.

// File: rtl/tpg_pkg.sv
// Package: shared encodings and polynomial lookup for the TMDS pattern generator.
// Assumes the LFSR register is at least as wide as the largest polynomial degree.
package tpg_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        SEL_ZERO  = 3'b000,
        SEL_DATA  = 3'b001,
        SEL_PRBS  = 3'b010,
        SEL_SHIFT = 3'b100
    } out_sel_e;

    typedef enum logic [1:0] {
        POLY_11 = 2'd0,
        POLY_15 = 2'd1,
        POLY_7  = 2'd2,
        POLY_31 = 2'd3
    } poly_e;

    typedef enum logic [1:0] {
        WID_IDLE = 2'd0,
        WID_8    = 2'd1,
        WID_1    = 2'd2,
        WID_10   = 2'd3
    } width_e;

    // Degree of the selected polynomial.
    function automatic int poly_degree(input logic [1:0] code);
        case (code)
            POLY_11: return 11;
            POLY_15: return 15;
            POLY_7:  return 7;
            default: return 31;
        endcase
    endfunction

    // Second feedback tap of the selected polynomial.
    function automatic int poly_tap(input logic [1:0] code);
        case (code)
            POLY_11: return 9;
            POLY_15: return 14;
            POLY_7:  return 6;
            default: return 28;
        endcase
    endfunction

endpackage

// File: rtl/tpg_prbs.sv
// Module: tpg_prbs
// Multi-polynomial Fibonacci LFSR that emits 0, 1, 8 or WORD_W bits per clock.
// The first bit of a clock lands in word bit 0. A change of polynomial code
// reloads all ones. A disabled or idle generator holds its state and outputs zero.
// Assumes LFSR_W >= 31 and WORD_W >= 8.
module tpg_prbs
    import tpg_pkg::*;
#(
    parameter int WORD_W = 10,
    parameter int LFSR_W = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        poly,
    input  logic [1:0]        width,
    output logic [WORD_W-1:0] word
);

    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] state_d;
    logic [1:0]        poly_q;

    // Purpose: compute this clock's bits and the next LFSR state.
    always_comb begin
        logic [LFSR_W-1:0] base;
        logic [LFSR_W-1:0] cur;
        logic [LFSR_W-1:0] mask;
        logic [WORD_W-1:0] bits;
        logic              nb;
        int                deg;
        int                tap;
        int                nbits;
        deg  = poly_degree(poly);
        tap  = poly_tap(poly);
        for (int j = 0; j < LFSR_W; j++) begin
            mask[j] = (j < deg);
        end
        base = (poly != poly_q) ? '1 : state_q;
        case (width)
            WID_8:   nbits = BYTE_BITS;
            WID_1:   nbits = 1;
            WID_10:  nbits = WORD_W;
            default: nbits = 0;
        endcase
        if (!en) begin
            nbits = 0;
        end
        cur  = base;
        bits = '0;
        for (int i = 0; i < WORD_W; i++) begin
            if (i < nbits) begin
                nb      = cur[deg-1] ^ cur[tap-1];
                bits[i] = nb;
                cur     = {cur[LFSR_W-2:0], nb} & mask;
            end
        end
        word    = bits;
        state_d = cur;
    end

    // Purpose: hold the LFSR state and the last-seen polynomial code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
            poly_q  <= '0;
        end else begin
            state_q <= state_d;
            poly_q  <= poly;
        end
    end

endmodule

// File: rtl/tpg_shift.sv
// Module: tpg_shift
// Replays NUM_WORDS programmed words in a ring, starting at the lowest word.
// Each word is held for hold+1 clocks. Disabled: holds its position, outputs zero.
// Assumes the hold field fits in HOLD_W bits.
module tpg_shift #(
    parameter int WORD_W    = 10,
    parameter int NUM_WORDS = 8,
    parameter int HOLD_W    = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [HOLD_W-1:0]           hold,
    input  logic [WORD_W*NUM_WORDS-1:0] pattern,
    output logic [WORD_W-1:0]           word
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

    logic [WORD_W-1:0] words [NUM_WORDS];
    logic [IDX_W-1:0]  idx_q;
    logic [HOLD_W-1:0] cnt_q;

    // Split the flat pattern into words, word 0 in the lowest bits.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_split
        assign words[g] = pattern[g*WORD_W +: WORD_W];
    end

    // Purpose: present the current word when enabled.
    always_comb begin
        word = en ? words[idx_q] : '0;
    end

    // Purpose: count hold clocks and step the word index around the ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (en) begin
            if (cnt_q >= hold) begin
                cnt_q <= '0;
                idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/tpg_out_sel.sv
// Module: tpg_out_sel
// Registered one-hot source selector. Unlisted select codes give zero.
module tpg_out_sel
    import tpg_pkg::*;
#(
    parameter int WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel,
    input  logic [WORD_W-1:0] data_word,
    input  logic [WORD_W-1:0] prbs_word,
    input  logic [WORD_W-1:0] shift_word,
    output logic [WORD_W-1:0] out_word
);

    logic [WORD_W-1:0] pick;

    // Purpose: choose the source for this clock.
    always_comb begin
        case (sel)
            SEL_DATA:  pick = data_word;
            SEL_PRBS:  pick = prbs_word;
            SEL_SHIFT: pick = shift_word;
            default:   pick = '0;
        endcase
    end

    // Purpose: register the chosen word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
        end else begin
            out_word <= pick;
        end
    end

endmodule

// File: rtl/tmds_pattern_gen.sv
// Module: tmds_pattern_gen
// Top level: TMDS word source for link tests. It combines a pass-through path,
// a pseudo-random engine and a programmable pattern replayer behind a
// registered selector.
// Assumes all control inputs are synchronous to clk.
module tmds_pattern_gen #(
    parameter int WORD_W    = 10,
    parameter int NUM_WORDS = 8,
    parameter int HOLD_W    = 3,
    parameter int LFSR_W    = 31
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WORD_W-1:0]           tmds_in,
    input  logic [2:0]                  out_sel,
    input  logic                        prbs_en,
    input  logic [1:0]                  prbs_poly,
    input  logic [1:0]                  prbs_width,
    input  logic                        shift_en,
    input  logic [HOLD_W-1:0]           shift_hold,
    input  logic [WORD_W*NUM_WORDS-1:0] shift_pattern,
    output logic [WORD_W-1:0]           tmds_out
);

    logic [WORD_W-1:0] prbs_word;
    logic [WORD_W-1:0] shift_word;

    tpg_prbs #(.WORD_W(WORD_W), .LFSR_W(LFSR_W)) u_prbs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (prbs_en),
        .poly  (prbs_poly),
        .width (prbs_width),
        .word  (prbs_word)
    );

    tpg_shift #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .HOLD_W(HOLD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (shift_en),
        .hold    (shift_hold),
        .pattern (shift_pattern),
        .word    (shift_word)
    );

    tpg_out_sel #(.WORD_W(WORD_W)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (out_sel),
        .data_word  (tmds_in),
        .prbs_word  (prbs_word),
        .shift_word (shift_word),
        .out_word   (tmds_out)
    );

endmodule

// File: rtl/tpg_checker.sv
// Module: tpg_checker
// Per-cycle output rules of tmds_pattern_gen, bound to the top.
module tpg_checker #(
    parameter int WORD_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] tmds_in,
    input logic [2:0]        out_sel,
    input logic              prbs_en,
    input logic [1:0]        prbs_width,
    input logic              shift_en,
    input logic [WORD_W-1:0] tmds_out
);

    logic sel_legal;
    assign sel_legal = (out_sel == 3'b001) || (out_sel == 3'b010) || (out_sel == 3'b100);

    AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b000) |=> (tmds_out == '0)); // R2
    AST_ILLEGAL_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_legal |=> (tmds_out == '0)); // R2
    AST_PASS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b001) |=> (tmds_out == $past(tmds_in))); // R3
    AST_PRBS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd1) |=> (tmds_out[WORD_W-1:8] == '0)); // R5
    AST_PRBS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd2) |=> (tmds_out[WORD_W-1:1] == '0)); // R5
    AST_PRBS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && prbs_width == 2'd0) |=> (tmds_out == '0)); // R5
    AST_PRBS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b010 && !prbs_en) |=> (tmds_out == '0)); // R6
    AST_SHIFT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sel == 3'b100 && !shift_en) |=> (tmds_out == '0)); // R10

endmodule

bind tmds_pattern_gen tpg_checker #(.WORD_W(WORD_W)) u_tpg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmds_in    (tmds_in),
    .out_sel    (out_sel),
    .prbs_en    (prbs_en),
    .prbs_width (prbs_width),
    .shift_en   (shift_en),
    .tmds_out   (tmds_out)
);

// File: tb/tmds_pattern_gen_bench.sv
`timescale 1ns/1ps
module tmds_pattern_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  tmds_in = '0;
    logic [2:0]  out_sel = '0;
    logic        prbs_en = 1'b0;
    logic [1:0]  prbs_poly = '0;
    logic [1:0]  prbs_width = '0;
    logic        shift_en = 1'b0;
    logic [2:0]  shift_hold = '0;
    logic [79:0] shift_pattern = '0;
    logic [9:0]  tmds_out;

    int errors = 0;
    int checks = 0;

    // Reference model state
    logic [30:0] m_lfsr;
    logic [1:0]  m_poly;
    int          m_idx;
    int          m_cnt;

    always #2.5 clk = ~clk;

    tmds_pattern_gen u_tmds_pattern_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .tmds_in       (tmds_in),
        .out_sel       (out_sel),
        .prbs_en       (prbs_en),
        .prbs_poly     (prbs_poly),
        .prbs_width    (prbs_width),
        .shift_en      (shift_en),
        .shift_hold    (shift_hold),
        .shift_pattern (shift_pattern),
        .tmds_out      (tmds_out)
    );

    // Advance the model by one clock and return the word the design must show.
    function automatic logic [9:0] model_step();
        logic [9:0] pw = '0;
        logic [9:0] sw = '0;
        logic [9:0] res;
        int d, t, n;
        logic nb;
        case (prbs_poly)
            2'd0: begin d = 11; t = 9;  end
            2'd1: begin d = 15; t = 14; end
            2'd2: begin d = 7;  t = 6;  end
            default: begin d = 31; t = 28; end
        endcase
        if (prbs_poly != m_poly) m_lfsr = '1;
        m_poly = prbs_poly;
        n = (!prbs_en) ? 0 : (prbs_width == 2'd1) ? 8 : (prbs_width == 2'd2) ? 1 :
            (prbs_width == 2'd3) ? 10 : 0;
        for (int i = 0; i < n; i++) begin
            nb = m_lfsr[d-1] ^ m_lfsr[t-1];
            pw[i] = nb;
            m_lfsr = {m_lfsr[29:0], nb};
            for (int k = d; k < 31; k++) m_lfsr[k] = 1'b0;
        end
        if (shift_en) begin
            sw = shift_pattern[m_idx*10 +: 10];
            if (m_cnt >= int'(shift_hold)) begin
                m_cnt = 0;
                m_idx = (m_idx + 1) % 8;
            end else begin
                m_cnt++;
            end
        end
        case (out_sel)
            3'b001:  res = tmds_in;
            3'b010:  res = pw;
            3'b100:  res = sw;
            default: res = '0;
        endcase
        return res;
    endfunction

    task automatic step(input string tag);
        logic [9:0] exp;
        exp = model_step();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (tmds_out !== exp) begin
            errors++;
            $display("FAIL %s: sel=%b poly=%0d wid=%0d hold=%0d actual=%h expected=%h",
                     tag, out_sel, prbs_poly, prbs_width, shift_hold, tmds_out, exp);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_lfsr = '1; m_poly = '0; m_idx = 0; m_cnt = 0;
        for (int i = 0; i < 8; i++) shift_pattern[i*10 +: 10] = 10'(i * 97 + 35);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step("R1");
        tmds_in = 10'h2A5;
        step("R2");
        // R3: pass-through sweep
        for (int v = 0; v < 1024; v += 37) begin
            out_sel = 3'b001; tmds_in = 10'(v);
            step("R3");
        end
        // R2: illegal select codes
        foreach (out_sel[i]) begin end
        for (int c = 3; c < 8; c++) begin
            if (c == 4) continue;
            out_sel = 3'(c); tmds_in = 10'h3FF;
            step("R2");
        end
        // R1 + R4: first PRBS words from reset seed, poly 0
        out_sel = 3'b010; prbs_en = 1'b1; prbs_width = 2'd3;
        for (int k = 0; k < 30; k++) step("R4");
        // R4 + R7: every polynomial, all widths
        for (int p = 0; p < 4; p++) begin
            prbs_poly = 2'(p);
            for (int w = 3; w >= 0; w--) begin
                prbs_width = 2'(w);
                for (int k = 0; k < 25; k++) step(w == 3 ? "R4" : "R5");
            end
        end
        // R6: disable holds, runs while unselected
        prbs_poly = 2'd3; prbs_width = 2'd3;
        prbs_en = 1'b0;
        for (int k = 0; k < 5; k++) step("R6");
        prbs_en = 1'b1;
        for (int k = 0; k < 5; k++) step("R6");
        out_sel = 3'b001;
        for (int k = 0; k < 7; k++) step("R6");
        out_sel = 3'b010;
        for (int k = 0; k < 5; k++) step("R6");
        // R7: change while disabled, then enable
        prbs_en = 1'b0; prbs_poly = 2'd2;
        step("R7");
        prbs_poly = 2'd1;
        step("R7");
        prbs_en = 1'b1;
        for (int k = 0; k < 6; k++) step("R7");
        // R8 + R9: pattern ring over all hold values
        out_sel = 3'b100; shift_en = 1'b1;
        for (int h = 0; h < 8; h++) begin
            shift_hold = 3'(h);
            for (int k = 0; k < 20 + 2 * h; k++) step(h == 0 ? "R8" : "R9");
        end
        // R10: disable holds position
        shift_hold = 3'd2;
        shift_en = 1'b0;
        for (int k = 0; k < 4; k++) step("R10");
        shift_en = 1'b1;
        for (int k = 0; k < 12; k++) step("R10");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule